// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block is the digital control path placed in front of a successive-approximation converter core. It holds four sample-and-hold channels. On each trigger it chooses the analog input that every channel selects, and it tells the channels when to sample. It then passes the active channels one after another to a single converter core through a request/done handshake. Each returned result is stored in a small result memory that software can read.

Channel 0 has a wide positive select and can scan over any subset of inputs. Channels 1 to 3 share one narrow group select. Two complete select sets can be used in alternating cycles. Sampling is either simultaneous with sequential conversion, or sample-then-convert one channel at a time. A 12-bit mode limits operation to channel 0. Results go either into a ring of entries that wraps at a programmable count, or all into entry 0. A one-cycle interrupt marks each wrap.

Top module: `adc_seq`

## Requirements
- R1: After reset, `busy`, `conv_req`, `irq` and `sample_en` are 0, and `ch0_pos`, `ch0_neg`, `grp_pos` and `grp_neg` are 0.
- R2: A `trig` pulse while idle starts a cycle, with `busy` high from the next clock. A `trig` that arrives while `busy` is high is ignored and starts no additional cycle.
- R3: With `cfg_simul`=0, each active channel k gets one cycle with `sample_en` equal to the one-hot value 1<<k. After that cycle comes its conversion request, and channels run in order 0,1,2,3. The first `conv_req` is high in the second cycle after the clock edge that captures `trig`.
- R4: With `cfg_simul`=1, a cycle has exactly one sampling cycle, in which `sample_en` has the bits of all active channels set. The conversion requests then follow for channels 0 upward, with no further sampling.
- R5: The active channel count is set by `cfg_chmode`: 00 gives channel 0 only, 01 gives channels 0–1, and 1x gives channels 0–3. With `cfg_mode12`=1, only channel 0 is active, whatever the value of `cfg_chmode`.
- R6: `conv_req` is a one-cycle pulse with `conv_ch` naming the channel. The next request, or the end of the cycle, comes only after `conv_done`.
- R7: With `cfg_alt`=1, the cycles after reset use set A, B, A, … for their selects. With `cfg_alt`=0, every cycle uses set A.
- R8: With `cfg_scan`=1 and a nonzero `cfg_scanmask`, channel 0's positive select steps through the set mask bits in ascending index order, one per cycle. After the highest set bit it returns to the lowest. With an empty mask, the positive select is set A's value, even in a B cycle.
- R9: In 10-bit mode the stored result keeps `conv_data[9:0]` with the upper bits cleared. In 12-bit mode all bits are stored.
- R10: With `cfg_single`=0, result number n (counted from reset) goes to entry n mod (`cfg_wrap_m1`+1). `irq` pulses for one cycle on each write to the last entry.
- R11: With `cfg_single`=1, every result goes to entry 0 and other entries keep their contents. The result count and `irq` still advance as in R10.
- R12: `ch0_neg`, `grp_pos` and `grp_neg` come from the set chosen for the cycle, and they are held for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Start-of-cycle pulse |
| cfg_simul | input | 1 | 1: sample all channels at once |
| cfg_chmode | input | 2 | Active channel count code |
| cfg_mode12 | input | 1 | 12-bit mode, channel 0 only |
| cfg_alt | input | 1 | Alternate set A/B per cycle |
| cfg_scan | input | 1 | Scan channel 0 over mask |
| cfg_scanmask | input | NUM_IN | Inputs included in scan |
| cfg_single | input | 1 | Store every result in entry 0 |
| cfg_wrap_m1 | input | log2(BUF_DEPTH) | Results per wrap minus one |
| a_ch0p | input | SEL_W | Set A channel 0 positive select |
| a_ch0n | input | 1 | Set A channel 0 negative select |
| a_grpp | input | 3 | Set A group positive select |
| a_grpn | input | 2 | Set A group negative select |
| b_ch0p | input | SEL_W | Set B channel 0 positive select |
| b_ch0n | input | 1 | Set B channel 0 negative select |
| b_grpp | input | 3 | Set B group positive select |
| b_grpn | input | 2 | Set B group negative select |
| ch0_pos | output | SEL_W | Channel 0 positive select |
| ch0_neg | output | 1 | Channel 0 negative select |
| grp_pos | output | 3 | Channels 1–3 positive select |
| grp_neg | output | 2 | Channels 1–3 negative select |
| sample_en | output | 4 | Per-channel sample strobe |
| conv_req | output | 1 | Conversion request pulse |
| conv_ch | output | 2 | Channel being converted |
| conv_done | input | 1 | Core result valid |
| conv_data | input | RES_W | Core result |
| rd_addr | input | log2(BUF_DEPTH) | Result read address |
| rd_data | output | RES_W | Result read data |
| busy | output | 1 | Cycle in progress |
| irq | output | 1 | Wrap interrupt pulse |

## Verification
After the edge that captures `trig`, the first sampling cycle is visible one clock later and the first `conv_req` two clocks later. The bench samples on falling edges at exactly those points. A result is written on the edge that follows the `conv_done` cycle, and `irq` rises on that same edge. For this reason the bench reads the result memory and the interrupt log only after `busy` has dropped and one more falling edge has passed. Selects, strobes and requests are logged on every falling edge. Each scenario then compares its log slice against the order and values the requirements predict.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NUM_IN    = 49,
  parameter int SEL_W     = 6,
  parameter int RES_W     = 12,
  parameter int BUF_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         trig,
  input  logic                         cfg_simul,
  input  logic [1:0]                   cfg_chmode,
  input  logic                         cfg_mode12,
  input  logic                         cfg_alt,
  input  logic                         cfg_scan,
  input  logic [NUM_IN-1:0]            cfg_scanmask,
  input  logic                         cfg_single,
  input  logic [$clog2(BUF_DEPTH)-1:0] cfg_wrap_m1,
  input  logic [SEL_W-1:0]             a_ch0p,
  input  logic                         a_ch0n,
  input  logic [2:0]                   a_grpp,
  input  logic [1:0]                   a_grpn,
  input  logic [SEL_W-1:0]             b_ch0p,
  input  logic                         b_ch0n,
  input  logic [2:0]                   b_grpp,
  input  logic [1:0]                   b_grpn,
  output logic [SEL_W-1:0]             ch0_pos,
  output logic                         ch0_neg,
  output logic [2:0]                   grp_pos,
  output logic [1:0]                   grp_neg,
  output logic [3:0]                   sample_en,
  output logic                         conv_req,
  output logic [1:0]                   conv_ch,
  input  logic                         conv_done,
  input  logic [RES_W-1:0]             conv_data,
  input  logic [$clog2(BUF_DEPTH)-1:0] rd_addr,
  output logic [RES_W-1:0]             rd_data,
  output logic                         busy,
  output logic                         irq
);
  localparam int PTR_W = $clog2(BUF_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_REQ, S_WAIT} st_t;

  st_t              st;
  logic [1:0]       ch, last_q;
  logic             simul_q, m12_q, alt_ph;
  logic [SEL_W-1:0] scan_ptr, pick;
  logic             hit;
  logic [PTR_W-1:0] res_cnt;
  logic [RES_W-1:0] mem [BUF_DEPTH];

  wire start   = (st == S_IDLE) && trig;
  wire use_b   = cfg_alt && alt_ph;
  wire last_ch = cfg_mode12 ? 1'b0 : 1'b1;
  wire [1:0] nlast = !last_ch ? 2'd0 : cfg_chmode[1] ? 2'd3 : cfg_chmode[0] ? 2'd1 : 2'd0;
  wire [3:0] act = (last_q == 2'd3) ? 4'b1111 : (last_q == 2'd1) ? 4'b0011 : 4'b0001;
  wire fin     = (st == S_WAIT) && conv_done;
  wire [PTR_W-1:0] wa = cfg_single ? '0 : res_cnt;
  wire [RES_W-1:0] store = m12_q ? conv_data : {{(RES_W-10){1'b0}}, conv_data[9:0]};

  assign busy      = (st != S_IDLE);
  assign conv_req  = (st == S_REQ);
  assign conv_ch   = ch;
  assign sample_en = (st != S_SAMP) ? 4'b0 : simul_q ? act : (4'b1 << ch);
  assign rd_data   = mem[rd_addr];

  always_comb begin
    logic [SEL_W-1:0] low;
    logic             any;
    hit  = 1'b0;
    pick = '0;
    low  = '0;
    any  = 1'b0;
    for (int i = NUM_IN-1; i >= 0; i--) begin
      if (cfg_scanmask[i]) begin
        low = SEL_W'(i);
        any = 1'b1;
        if (i >= int'(scan_ptr)) begin
          pick = SEL_W'(i);
          hit  = 1'b1;
        end
      end
    end
    if (!hit) begin
      pick = low;
      hit  = any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ch       <= '0;
      last_q   <= '0;
      simul_q  <= 1'b0;
      m12_q    <= 1'b0;
      alt_ph   <= 1'b0;
      scan_ptr <= '0;
      ch0_pos  <= '0;
      ch0_neg  <= 1'b0;
      grp_pos  <= '0;
      grp_neg  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_SAMP;
          ch      <= '0;
          last_q  <= nlast;
          simul_q <= cfg_simul;
          m12_q   <= cfg_mode12;
          ch0_neg <= use_b ? b_ch0n : a_ch0n;
          grp_pos <= use_b ? b_grpp : a_grpp;
          grp_neg <= use_b ? b_grpn : a_grpn;
          if (cfg_scan && hit) begin
            ch0_pos  <= pick;
            scan_ptr <= pick + 1'b1;
          end else if (cfg_scan) begin
            ch0_pos <= a_ch0p;
          end else begin
            ch0_pos <= use_b ? b_ch0p : a_ch0p;
          end
        end
        S_SAMP: st <= S_REQ;
        S_REQ:  st <= S_WAIT;
        S_WAIT: if (conv_done) begin
          if (ch == last_q) begin
            st     <= S_IDLE;
            alt_ph <= cfg_alt ? !alt_ph : 1'b0;
          end else begin
            ch <= ch + 1'b1;
            st <= simul_q ? S_REQ : S_SAMP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_cnt <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= fin && (res_cnt == cfg_wrap_m1);
      if (fin) res_cnt <= (res_cnt == cfg_wrap_m1) ? '0 : res_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fin) mem[wa] <= store;
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig,
  input logic       busy,
  input logic       conv_req,
  input logic       conv_done,
  input logic [3:0] sample_en,
  input logic       irq
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig) |=> busy);
  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  // R6
  end_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done));
  // R4
  samp_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en != 4'b0) |-> !conv_req);
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .conv_req(conv_req),
  .conv_done(conv_done), .sample_en(sample_en), .irq(irq)
);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 49;

  logic clk = 0, rst_n = 0, trig = 0;
  logic cfg_simul = 0, cfg_mode12 = 0, cfg_alt = 0, cfg_scan = 0, cfg_single = 0;
  logic [1:0] cfg_chmode = 0;
  logic [NIN-1:0] cfg_scanmask = '0;
  logic [3:0] cfg_wrap_m1 = 4'd15;
  logic [5:0] a_ch0p = 6'd5, b_ch0p = 6'd33;
  logic a_ch0n = 0, b_ch0n = 1;
  logic [2:0] a_grpp = 3'd2, b_grpp = 3'd6;
  logic [1:0] a_grpn = 2'd1, b_grpn = 2'd3;
  logic [5:0] ch0_pos;
  logic ch0_neg, conv_req, busy, irq, conv_done = 0;
  logic [2:0] grp_pos;
  logic [1:0] grp_neg, conv_ch;
  logic [3:0] sample_en, rd_addr = 0;
  logic [11:0] conv_data = 0, rd_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  adc_seq u_adc_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // converter core model: done three clocks after the request edge
  int lat = 0;
  logic [1:0] pch = 0;
  logic [5:0] seq = 0;
  always @(posedge clk) begin
    conv_done <= 0;
    if (conv_req) begin
      lat <= 3; pch <= conv_ch;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        conv_done <= 1;
        conv_data <= {4'hC, pch, seq};
        seq <= seq + 1;
      end
    end
  end

  // logs
  logic [3:0]  smp [512];
  logic [1:0]  rq  [512];
  logic [5:0]  c0p [512];
  logic        c0n [512];
  logic [4:0]  gp  [512];
  logic [11:0] dl  [512];
  int          ia  [512];
  int ns = 0, nr = 0, nc = 0, nd = 0, ni = 0;
  always @(negedge clk) begin
    if (sample_en != 0) begin smp[ns] = sample_en; ns++; end
    if (conv_req) begin
      rq[nr] = conv_ch; nr++;
      if (conv_ch == 0) begin
        c0p[nc] = ch0_pos; c0n[nc] = ch0_neg; gp[nc] = {grp_pos, grp_neg}; nc++;
      end
    end
    if (conv_done) begin dl[nd] = conv_data; nd++; end
    if (irq) begin ia[ni] = nd; ni++; end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; trig = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_cycle();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_buf(input logic [3:0] a, output logic [11:0] d);
    @(negedge clk) rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    rst_n = 0;
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 req", conv_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sample", sample_en, 0);
    chk("R1 sel", {ch0_pos, ch0_neg, grp_pos, grp_neg}, 0);
    do_reset();
  endtask

  task automatic t_seq4();
    int s0, r0, d0;
    logic [11:0] v;
    do_reset();
    cfg_chmode = 2'b10; cfg_simul = 0; cfg_mode12 = 0;
    s0 = ns; r0 = nr; d0 = nd;
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
    chk("R2 busy after trig", busy, 1);
    chk("R3 sample ch0 first", sample_en, 4'b0001);
    chk("R3 no req yet", conv_req, 0);
    @(negedge clk);
    chk("R3 first req timing", conv_req, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R3 sample count", ns - s0, 4);
    chk("R5 req count 4ch", nr - r0, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R3 onehot sample order", smp[s0+k], 4'b1 << k);
      chk("R6 req channel order", rq[r0+k], k);
      read_buf(k[3:0], v);
      chk("R9 10-bit masked store", v, dl[d0+k] & 12'h3FF);
    end
  endtask

  task automatic t_simul2();
    int s0, r0;
    do_reset();
    cfg_chmode = 2'b01; cfg_simul = 1; cfg_mode12 = 0;
    s0 = ns; r0 = nr;
    run_cycle();
    chk("R4 single sample cycle", ns - s0, 1);
    chk("R4 both channels sampled", smp[s0], 4'b0011);
    chk("R5 req count 2ch", nr - r0, 2);
    chk("R4 req ch0", rq[r0], 0);
    chk("R4 req ch1", rq[r0+1], 1);
    cfg_simul = 0;
  endtask

  task automatic t_m12();
    int r0, d0;
    logic [11:0] v;
    do_reset();
    cfg_chmode = 2'b10; cfg_mode12 = 1;
    r0 = nr; d0 = nd;
    run_cycle();
    chk("R5 12-bit one channel", nr - r0, 1);
    read_buf(0, v);
    chk("R9 12-bit full store", v, dl[d0]);
    cfg_mode12 = 0; cfg_chmode = 0;
  endtask

  task automatic t_alt();
    int c0;
    do_reset();
    cfg_chmode = 0; cfg_alt = 1;
    c0 = nc;
    repeat (3) run_cycle();
    chk("R7 cycle1 A", c0p[c0], a_ch0p);
    chk("R7 cycle2 B", c0p[c0+1], b_ch0p);
    chk("R7 cycle3 A", c0p[c0+2], a_ch0p);
    chk("R12 group A", gp[c0], {a_grpp, a_grpn});
    chk("R12 group B", gp[c0+1], {b_grpp, b_grpn});
    chk("R12 neg B", c0n[c0+1], b_ch0n);
    cfg_alt = 0;
    c0 = nc;
    repeat (2) run_cycle();
    chk("R7 no alt A", c0p[c0+1], a_ch0p);
    chk("R12 no alt group A", gp[c0+1], {a_grpp, a_grpn});
  endtask

  task automatic t_scan();
    int c0;
    do_reset();
    cfg_scan = 1; cfg_scanmask = '0;
    cfg_scanmask[3] = 1; cfg_scanmask[10] = 1; cfg_scanmask[48] = 1;
    c0 = nc;
    repeat (4) run_cycle();
    chk("R8 scan 1st", c0p[c0], 3);
    chk("R8 scan 2nd", c0p[c0+1], 10);
    chk("R8 scan 3rd", c0p[c0+2], 48);
    chk("R8 scan wrap", c0p[c0+3], 3);
    do_reset();
    cfg_scanmask = '0; cfg_alt = 1;
    c0 = nc;
    repeat (2) run_cycle();
    chk("R8 empty mask A", c0p[c0], a_ch0p);
    chk("R8 empty mask B cycle uses A", c0p[c0+1], a_ch0p);
    chk("R12 empty mask neg from B", c0n[c0+1], b_ch0n);
    cfg_scan = 0; cfg_alt = 0;
  endtask

  task automatic t_busy();
    int r0;
    do_reset();
    cfg_chmode = 0;
    r0 = nr;
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
    repeat (2) @(negedge clk);
    trig = 1;
    @(negedge clk) trig = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2 trigger while busy ignored", nr - r0, 1);
    chk("R2 idle afterwards", busy, 0);
  endtask

  task automatic t_wrap();
    int d0, i0;
    logic [11:0] v;
    do_reset();
    cfg_chmode = 0; cfg_wrap_m1 = 4'd2; cfg_single = 0;
    d0 = nd; i0 = ni;
    repeat (7) run_cycle();
    chk("R10 irq count", ni - i0, 2);
    chk("R10 irq at 3rd result", ia[i0] - d0, 3);
    chk("R10 irq at 6th result", ia[i0+1] - d0, 6);
    read_buf(0, v);
    chk("R10 entry0 wrapped", v, dl[d0+6] & 12'h3FF);
    read_buf(2, v);
    chk("R10 entry2", v, dl[d0+5] & 12'h3FF);
  endtask

  task automatic t_single();
    int d0, i0;
    logic [11:0] v;
    do_reset();
    cfg_chmode = 0; cfg_wrap_m1 = 4'd2; cfg_single = 0;
    d0 = nd; i0 = ni;
    repeat (2) run_cycle();
    cfg_single = 1;
    repeat (3) run_cycle();
    read_buf(0, v);
    chk("R11 entry0 last result", v, dl[d0+4] & 12'h3FF);
    read_buf(1, v);
    chk("R11 entry1 untouched", v, dl[d0+1] & 12'h3FF);
    chk("R11 irq count", ni - i0, 1);
    chk("R11 irq at 3rd result", ia[i0] - d0, 3);
    cfg_single = 0; cfg_wrap_m1 = 4'd15;
  endtask

  initial begin
    t_reset();
    t_seq4();
    t_simul2();
    t_m12();
    t_alt();
    t_scan();
    t_busy();
    t_wrap();
    t_single();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule